// File: doc/BRIEF.md
# 64-bit Global Tick Timer with Self-Rearming Comparator

This block is a memory-mapped system timer. It keeps a 64-bit up-counter that advances once per clock while its run bit is set, and a single 64-bit compare value. When the counter equals the compare value and the comparator is enabled, a match flag sets. That flag drives a level interrupt, gated by an enable bit. In periodic mode the comparator adds a programmable 32-bit step to itself on every match, so events keep arriving at a fixed spacing without software rewriting the compare value.

Software reaches the block over a simple register port with address, write data, write strobe, read strobe and registered read data. Writes that change timer state take effect a fixed number of cycles after the strobe (parameter `WR_DELAY`, default 4). Each such write then sets its own sticky completion bit, which software clears by writing 1 to that bit. The two counter halves are read separately and are not latched together. Software assembles a coherent 64-bit value by reading high, low and high again, and retries until the two high reads agree.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the counter, compare value, step, control, interrupt status, interrupt enable and all completion bits read 0, and `irq` is low.
- R2: While control bit 8 (run) is set, the counter rises by exactly one per clock, carrying from the low half into the high half.
- R3: A write to the counter halves (0x100 low, 0x104 high), compare halves (0x200, 0x204), step (0x208), control (0x240), interrupt enable (0x248) or interrupt status (0x244) changes nothing until `WR_DELAY` clocks after the strobe. At that edge it takes effect and its completion bit sets.
- R4: Completion bits sit at 0x24C (bit 0 compare-low, bit 1 compare-high, bit 2 step, bit 16 control) and at 0x110 (bit 0 counter-low, bit 1 counter-high). Each stays set until a write with a 1 in that position clears it at once. A write of 0 leaves it set.
- R5: A counter-half write replaces only that half. While run is clear and no counter write lands, the counter holds its value.
- R6: Control bit 0 enables the comparator. The step from "counter differs from compare value" to "counter equals compare value" sets status bit 0 of 0x244 once. No match is flagged while bit 0 is clear, and a match that persists does not set the flag again after it is cleared.
- R7: `irq` is high exactly while status bit 0 and enable bit 0 of 0x248 are both set. Writing 1 to status bit 0 clears it.
- R8: With control bit 1 set, each match adds the step value to the full 64-bit compare value, so matches repeat every step-value clocks. With bit 1 clear, the compare value is left unchanged.
- R9: A read returns the addressed register one clock after the read strobe. Control reads back only bits 8, 1 and 0, and unmapped addresses read 0.
- R10: A high-low-high read sequence with retry yields a consistent 64-bit count even when the low half wraps during the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Register byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the clock after `rdEn` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong counter value shows at the counter read ports on the next read, and a stuck run bit shows as two back-to-back reads that differ by other than one. A comparator or step register holding the wrong value moves the `irq` rising edge by a measurable number of clocks, and a broken carry shows in the compare high half one read after the match. A wrong write-delay stage count is caught by reading a register and its completion bit at the exact edge before and after the write is due to land.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h104;
  localparam logic [ADDR_W-1:0] A_CWSTAT  = 12'h110;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h204;
  localparam logic [ADDR_W-1:0] A_STEP    = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h240;
  localparam logic [ADDR_W-1:0] A_ISTAT   = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN     = 12'h248;
  localparam logic [ADDR_W-1:0] A_GWSTAT  = 12'h24C;

  localparam int BIT_RUN   = 8;
  localparam int BIT_AUTO  = 1;
  localparam int BIT_CMPEN = 0;
  localparam int BIT_WSCTL = 16;

  // decoded, delayed write strobes from control to datapath
  typedef struct packed {
    logic cntLo;
    logic cntHi;
    logic cmpLo;
    logic cmpHi;
    logic step;
    logic ctrl;
    logic intEn;
    logic intClr;
    logic [DATA_W-1:0] data;
  } commit_t;

  // datapath state visible to the read mux
  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [DATA_W-1:0] step;
    logic run;
    logic autoInc;
    logic cmpEn;
    logic intStat;
    logic intEn;
  } view_t;
endpackage

// File: rtl/stt_ctrl.sv
module stt_ctrl
  import stt_pkg::*;
#(
  parameter int WR_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  view_t             view,
  output commit_t           commit,
  output logic [3:0]        wstatG,
  output logic [1:0]        wstatC,
  output logic [DATA_W-1:0] rdData
);
  commit_t dec;
  commit_t [WR_DELAY-1:0] pipe;

  always_comb begin
    dec = '0;
    dec.data = wrData;
    if (wrEn) begin
      unique case (addr)
        A_CNT_LO: dec.cntLo  = 1'b1;
        A_CNT_HI: dec.cntHi  = 1'b1;
        A_CMP_LO: dec.cmpLo  = 1'b1;
        A_CMP_HI: dec.cmpHi  = 1'b1;
        A_STEP:   dec.step   = 1'b1;
        A_CTRL:   dec.ctrl   = 1'b1;
        A_IEN:    dec.intEn  = 1'b1;
        A_ISTAT:  dec.intClr = 1'b1;
        default:  ;
      endcase
    end
  end

  // delay line: one stage per clock of write latency
  generate
    if (WR_DELAY == 1) begin : g_oneStage
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '0;
        else       pipe <= dec;
    end else begin : g_multiStage
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[WR_DELAY-2:0], dec};
    end
  endgenerate

  assign commit = pipe[WR_DELAY-1];

  logic [3:0] clrG, setG;
  logic [1:0] clrC, setC;

  always_comb begin
    clrG = '0;
    clrC = '0;
    if (wrEn && addr == A_GWSTAT) clrG = {wrData[BIT_WSCTL], wrData[2:0]};
    if (wrEn && addr == A_CWSTAT) clrC = wrData[1:0];
    setG = {commit.ctrl, commit.step, commit.cmpHi, commit.cmpLo};
    setC = {commit.cntHi, commit.cntLo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wstatG <= '0;
      wstatC <= '0;
    end else begin
      wstatG <= (wstatG & ~clrG) | setG;
      wstatC <= (wstatC & ~clrC) | setC;
    end
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (addr)
      A_CNT_LO: rdNext = view.cnt[HALF_W-1:0];
      A_CNT_HI: rdNext = view.cnt[CNT_W-1:HALF_W];
      A_CWSTAT: rdNext = {30'b0, wstatC};
      A_CMP_LO: rdNext = view.cmp[HALF_W-1:0];
      A_CMP_HI: rdNext = view.cmp[CNT_W-1:HALF_W];
      A_STEP:   rdNext = view.step;
      A_CTRL:   rdNext = {23'b0, view.run, 6'b0, view.autoInc, view.cmpEn};
      A_ISTAT:  rdNext = {31'b0, view.intStat};
      A_IEN:    rdNext = {31'b0, view.intEn};
      A_GWSTAT: rdNext = {15'b0, wstatG[3], 13'b0, wstatG[2:0]};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
endmodule

// File: rtl/stt_datapath.sv
module stt_datapath
  import stt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  commit_t commit,
  output view_t   view,
  output logic    irq
);
  logic [CNT_W-1:0]  cnt, cmp;
  logic [DATA_W-1:0] step;
  logic run, autoInc, cmpEn, intStat, intEn, matchQ;
  logic matchNow, hit;

  assign matchNow = cmpEn && (cnt == cmp);
  assign hit      = matchNow && !matchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (commit.cntLo) cnt[HALF_W-1:0] <= commit.data;
    else if (commit.cntHi) cnt[CNT_W-1:HALF_W] <= commit.data;
    else if (run)          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cmp <= '0;
    else if (commit.cmpLo)   cmp[HALF_W-1:0] <= commit.data;
    else if (commit.cmpHi)   cmp[CNT_W-1:HALF_W] <= commit.data;
    else if (hit && autoInc) cmp <= cmp + {{(CNT_W-DATA_W){1'b0}}, step};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= '0;
      run     <= 1'b0;
      autoInc <= 1'b0;
      cmpEn   <= 1'b0;
      intEn   <= 1'b0;
      intStat <= 1'b0;
      matchQ  <= 1'b0;
    end else begin
      matchQ <= matchNow;
      if (commit.step) step <= commit.data;
      if (commit.ctrl) begin
        run     <= commit.data[BIT_RUN];
        autoInc <= commit.data[BIT_AUTO];
        cmpEn   <= commit.data[BIT_CMPEN];
      end
      if (commit.intEn) intEn <= commit.data[0];
      if (hit)                                intStat <= 1'b1;
      else if (commit.intClr && commit.data[0]) intStat <= 1'b0;
    end
  end

  assign irq = intStat && intEn;

  always_comb begin
    view.cnt     = cnt;
    view.cmp     = cmp;
    view.step    = step;
    view.run     = run;
    view.autoInc = autoInc;
    view.cmpEn   = cmpEn;
    view.intStat = intStat;
    view.intEn   = intEn;
  end
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stt_pkg::*;
#(
  parameter int WR_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  commit_t    commit;
  view_t      view;
  logic [3:0] wstatG;
  logic [1:0] wstatC;

  stt_ctrl #(.WR_DELAY(WR_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .view(view), .commit(commit), .wstatG(wstatG),
    .wstatC(wstatC), .rdData(rdData)
  );

  stt_datapath dp_i (
    .clk(clk), .rstN(rstN), .commit(commit), .view(view), .irq(irq)
  );
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk
  import stt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input commit_t           commit,
  input view_t             view,
  input logic [3:0]        wstatG
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (view.run && !commit.cntLo && !commit.cntHi) |=> view.cnt == $past(view.cnt) + 1'b1);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!view.run && !commit.cntLo && !commit.cntHi) |=> $stable(view.cnt));

  // R4
  wstat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wstatG[0] && !(wrEn && addr == A_GWSTAT && wrData[0])) |=> wstatG[0]);

  // R3
  wstat_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wstatG[2]) |-> $past(commit.step));

  // R6
  match_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(view.intStat) |-> $past(view.cmpEn && view.cnt == view.cmp));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !commit.intEn && !commit.intClr) |=> irq);

  // R8
  rearm_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(view.intStat) && $past(view.autoInc) && !$past(commit.cmpLo) && !$past(commit.cmpHi))
      |-> view.cmp == $past(view.cmp) + {32'b0, $past(view.step)});
endmodule

bind sys_tick_timer sys_tick_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irq(irq), .commit(commit), .view(view), .wstatG(wstatG)
);

// File: tb/sys_tick_timer_tb_top.sv
module sys_tick_timer_tb_top;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int nTests = 0;
  int nFail = 0;
  longint cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sys_tick_timer #(.WR_DELAY(D)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // write address, write data, read address, expected read
  localparam logic [127:0] VEC [0:8] = '{
    {32'h208, 32'h0000_0020, 32'h208, 32'h0000_0020},
    {32'h200, 32'h1234_5678, 32'h200, 32'h1234_5678},
    {32'h204, 32'h0000_00AB, 32'h204, 32'h0000_00AB},
    {32'h248, 32'h0000_0001, 32'h248, 32'h0000_0001},
    {32'h100, 32'h0000_0055, 32'h100, 32'h0000_0055},
    {32'h104, 32'h0000_0007, 32'h104, 32'h0000_0007},
    {32'h240, 32'h0000_0003, 32'h240, 32'h0000_0003},
    {32'h240, 32'h0000_00FC, 32'h240, 32'h0000_0000},
    {32'h300, 32'hDEAD_BEEF, 32'h300, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read64(output logic [63:0] v, inout int retries);
    logic [31:0] hi1, lo, hi2;
    rd(12'h104, hi1);
    for (int k = 0; k < 8; k++) begin
      rd(12'h100, lo);
      rd(12'h104, hi2);
      if (hi1 == hi2) break;
      hi1 = hi2;
      retries++;
    end
    v = {hi2, lo};
  endtask

  task automatic waitIrq(input logic lvl, input int limit, output longint t);
    int n = 0;
    while (irq !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r, a, b;
    logic [63:0] v, prev;
    longint t1, t2;
    int retries;

    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq", {63'b0, irq}, 64'd0);
    rd(12'h240, r); chk("R1 ctrl", r, 0);
    rd(12'h244, r); chk("R1 status", r, 0);
    rd(12'h24C, r); chk("R1 wstat", r, 0);
    rd(12'h110, r); chk("R1 cnt wstat", r, 0);
    rd(12'h100, r); chk("R1 cnt lo", r, 0);
    rd(12'h204, r); chk("R1 cmp hi", r, 0);

    // R9 register map walk
    foreach (VEC[i]) begin
      wr(VEC[i][107:96], VEC[i][95:64]);
      idle(D);
      rd(VEC[i][43:32], r);
      chk($sformatf("R9 vector %0d", i), r, {32'b0, VEC[i][31:0]});
    end

    // R4 bit positions and write-1-to-clear
    rd(12'h24C, r); chk("R4 all wstat set", r, 32'h0001_0007);
    rd(12'h110, r); chk("R4 cnt wstat set", r, 32'h3);
    wr(12'h24C, 32'h0); idle(1);
    rd(12'h24C, r); chk("R4 zero write keeps", r, 32'h0001_0007);
    wr(12'h24C, 32'h1);
    rd(12'h24C, r); chk("R4 clear bit0", r, 32'h0001_0006);
    wr(12'h24C, 32'h0001_0006);
    wr(12'h110, 32'h3);
    rd(12'h24C, r); chk("R4 clear rest", r, 0);
    rd(12'h110, r); chk("R4 clear cnt", r, 0);

    // R3 exact landing edge
    wr(12'h208, 32'h40);
    idle(D - 1);
    rd(12'h208, r); chk("R3 step before due", r, 32'h20);
    rd(12'h208, r); chk("R3 step after due", r, 32'h40);
    wr(12'h24C, 32'h4);
    wr(12'h208, 32'h20);
    idle(D - 1);
    rd(12'h24C, r); chk("R3 wstat before due", r, 0);
    rd(12'h24C, r); chk("R3 wstat after due", r, 32'h4);
    idle(20);
    rd(12'h24C, r); chk("R4 sticky", r, 32'h4);
    wr(12'h24C, 32'h4);

    // R2 running counter
    wr(12'h240, 32'h100); idle(D);
    rd(12'h100, a); rd(12'h100, b);
    chk("R2 one per clock", b - a, 1);

    // R5 halt and direct half loads
    wr(12'h240, 32'h0); idle(D);
    rd(12'h100, a); idle(5); rd(12'h100, b);
    chk("R5 halted", b, a);
    wr(12'h104, 32'h9); wr(12'h100, 32'hFFFF_FFF0); idle(D);
    rd(12'h104, r); chk("R5 hi load", r, 32'h9);
    rd(12'h100, r); chk("R5 lo load", r, 32'hFFFF_FFF0);
    rd(12'h110, r); chk("R4 cnt wstat bits", r, 32'h3);

    // R10 coherent read across a low-half wrap
    wr(12'h240, 32'h100);
    retries = 0;
    prev = 64'h9_FFFF_FFF0;
    for (int k = 0; k < 12; k++) begin
      read64(v, retries);
      if (v[63:32] == 32'h9) chk("R10 pre-wrap low", {63'b0, v[31:0] >= 32'hFFFF_FFF0}, 1);
      else begin
        chk("R10 post-wrap high", v[63:32], 32'hA);
        chk("R10 post-wrap low", {63'b0, v[31:0] < 32'h100}, 1);
      end
      chk("R10 monotonic", {63'b0, v >= prev}, 1);
      prev = v;
    end
    chk("R10 final high", prev[63:32], 32'hA);
    wr(12'h240, 32'h0); idle(D);

    // R6 no match while comparator disabled
    wr(12'h104, 0); wr(12'h100, 100);
    wr(12'h204, 0); wr(12'h200, 100);
    idle(D + 2);
    rd(12'h244, r); chk("R6 disabled no flag", r, 0);
    // R6 persistent match flags once
    wr(12'h240, 32'h001); idle(D + 2);
    rd(12'h244, r); chk("R6 match flag", r, 1);
    wr(12'h244, 32'h1); idle(D + 2);
    rd(12'h244, r); chk("R6 no re-flag", r, 0);
    chk("R6 irq low", {63'b0, irq}, 0);

    // R7 one-shot interrupt and gating
    wr(12'h240, 32'h0);
    wr(12'h100, 0); wr(12'h200, 30); idle(D);
    wr(12'h240, 32'h101);
    waitIrq(1'b1, 100, t1);
    chk("R7 irq on match", {63'b0, irq}, 1);
    wr(12'h248, 32'h0); idle(D);
    chk("R7 irq gated off", {63'b0, irq}, 0);
    rd(12'h244, r); chk("R7 status kept", r, 1);
    wr(12'h248, 32'h1); idle(D);
    chk("R7 irq regated", {63'b0, irq}, 1);
    wr(12'h244, 32'h1); idle(D);
    chk("R7 irq cleared", {63'b0, irq}, 0);
    idle(50);
    chk("R6 one-shot passes", {63'b0, irq}, 0);
    rd(12'h200, r); chk("R8 no rearm when off", r, 30);

    // R8 periodic spacing
    wr(12'h240, 32'h0);
    wr(12'h100, 0); wr(12'h200, 40); wr(12'h208, 25); idle(D);
    wr(12'h240, 32'h103);
    waitIrq(1'b1, 200, t1);
    wr(12'h244, 32'h1);
    waitIrq(1'b0, 50, t2);
    waitIrq(1'b1, 200, t2);
    chk("R8 period", t2 - t1, 25);
    wr(12'h240, 32'h0); idle(D);
    rd(12'h200, r); chk("R8 compare advanced", r, 90);

    // R8 64-bit carry into compare high half
    wr(12'h244, 32'h1);
    wr(12'h104, 0); wr(12'h100, 32'hFFFF_FFE0);
    wr(12'h204, 0); wr(12'h200, 32'hFFFF_FFF0);
    wr(12'h208, 32'h20); idle(D);
    wr(12'h240, 32'h103);
    waitIrq(1'b1, 200, t1);
    wr(12'h240, 32'h0); idle(D);
    rd(12'h204, r); chk("R8 carry high", r, 1);
    rd(12'h200, r); chk("R8 carry low", r, 32'h10);

    summary();
    $finish;
  end
endmodule